// File: doc/BRIEF.md
# Selector-Driven Register File Sequencer

This block holds sixteen 16-bit general registers and a small control engine that treats any one of them as the program counter. A 4-bit selector `P` names the register used for instruction fetch, and a second 4-bit selector `X` names the register that serves as data pointer. A subroutine call or return therefore costs a single selector change: the caller's counter stays where it was, and the called code runs from whatever register `P` now names.

Every instruction takes a fetch cycle followed by an execute cycle. In the fetch cycle the engine reads one byte through the `P`-selected register, steps that register up by one, and splits the byte into a high nibble `I` and a low nibble `N`. In the execute cycle it carries out the register operation those nibbles name. An interrupt request that is present at the end of an execute cycle, while interrupts are enabled, inserts one entry cycle. That cycle saves the selectors, forces them to the service values and disables further entries. Arithmetic, branching and I/O live elsewhere. This block only sequences the register file.

Top module: `ptrSeq`

## Requirements
- R1: While reset is held and in the first cycle after it, the selectors `P` and `X`, the nibbles `I` and `N`, and the saved byte `T` all read zero. All sixteen registers are zero, so the first fetch drives address 0x0000 with `memRd` high.
- R2: Fetch and execute cycles alternate. `memRd` is high only in fetch cycles, where `memAddr` equals the `P`-selected register. After a fetch, `I` holds bits 7:4 of the byte read and `N` holds bits 3:0.
- R3: Each fetch adds one, modulo 2^16, to the register that drove the address. 0xFFFF wraps to 0x0000.
- R4: Opcode 0xDn (I = 0xD) loads `N` into `P`. From the next fetch on, register n supplies the address.
- R5: Opcode 0xEn (I = 0xE) loads `N` into `X`. `P` and the registers are untouched.
- R6: Opcode 0x1n adds one to register n, and opcode 0x2n subtracts one from register n, both modulo 2^16. Register 0 minus one gives 0xFFFF.
- R7: Opcode 0xC4, and every opcode whose high nibble is not 1, 2, 0xD or 0xE, changes no register, selector or saved byte beyond the fetch increment.
- R8: If `irq` is high at the end of an execute cycle while interrupts are enabled, the next cycle is an entry cycle with `memRd` low. After that cycle, `T` = {old X, old P}, `X` = 2, `P` = 1 and interrupts are disabled. The next fetch then goes through register 1.
- R9: While interrupts are disabled, `irq` has no effect. Only reset enables them again, so a level held high produces exactly one entry per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memAddr | output | 16 | Fetch address, the `P`-selected register |
| memRd | output | 1 | High in fetch cycles |
| memRdata | input | 8 | Byte at `memAddr`, valid in the same cycle |
| irq | input | 1 | Level-sensitive interrupt request |
| dbgP | output | 4 | Program counter selector |
| dbgX | output | 4 | Data pointer selector |
| dbgI | output | 4 | High nibble of the last fetched byte |
| dbgN | output | 4 | Low nibble of the last fetched byte |
| dbgT | output | 8 | Saved {X, P} from the last interrupt entry |

## Verification
A wrong register value inside the file stays hidden until that register next drives a fetch. The bench therefore moves `P` across the file with SEP, so every register's content reaches `memAddr` within a few instructions of being changed. A selector or nibble error shows on the debug outputs in the cycle right after the faulty edge. A phase error shows at once as a wrong `memRd` pattern. A wrongly taken or missed interrupt entry shows as a second low `memRd` cycle, or the lack of one, in the following cycle.

// File: rtl/ptrSeqPkg.sv
package ptrSeqPkg;
  parameter int OP_W  = 8;
  parameter int NIB_W = OP_W / 2;
  parameter int NREG  = 1 << NIB_W;

  // high-nibble opcode classes
  localparam logic [NIB_W-1:0] OPC_INC = 4'h1;
  localparam logic [NIB_W-1:0] OPC_DEC = 4'h2;
  localparam logic [NIB_W-1:0] OPC_SEP = 4'hD;
  localparam logic [NIB_W-1:0] OPC_SEX = 4'hE;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_INTR  = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             bump;     // add one to register sel
    logic             down;     // subtract one from register sel
    logic [NIB_W-1:0] sel;      // register being stepped
    logic [NIB_W-1:0] addrSel;  // register driving the address
  } dpCtrl_t;
endpackage

// File: rtl/ptrSeqDatapath.sv
module ptrSeqDatapath
  import ptrSeqPkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  output logic [REG_W-1:0] memAddr
);
  logic [REG_W-1:0] rfView [NREG];
  logic [REG_W-1:0] cur;
  logic [REG_W-1:0] stepped;
  logic             stepEn;

  // one shared incrementer/decrementer, one register written per cycle
  assign cur     = rfView[ctrl.sel];
  assign stepped = ctrl.down ? cur - REG_W'(1) : cur + REG_W'(1);
  assign stepEn  = ctrl.bump || ctrl.down;

  generate
    for (genvar k = 0; k < NREG; k++) begin : g_reg
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          q <= '0;
        end else if (stepEn && (ctrl.sel == NIB_W'(k))) begin
          q <= stepped;
        end
      end
      assign rfView[k] = q;
    end
  endgenerate

  assign memAddr = rfView[ctrl.addrSel];
endmodule

// File: rtl/ptrSeqCtrl.sv
module ptrSeqCtrl
  import ptrSeqPkg::*;
#(
  parameter logic [NIB_W-1:0] INT_X = 4'd2,
  parameter logic [NIB_W-1:0] INT_P = 4'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   memRdata,
  input  logic              irq,
  output logic              memRd,
  output dpCtrl_t           ctrl,
  output logic [NIB_W-1:0]  pSel,
  output logic [NIB_W-1:0]  xSel,
  output logic [NIB_W-1:0]  iNib,
  output logic [NIB_W-1:0]  nNib,
  output logic [OP_W-1:0]   tSave
);
  phase_t phase;
  logic   intEn;

  assign memRd = (phase == PH_FETCH);

  always_comb begin
    ctrl.bump    = 1'b0;
    ctrl.down    = 1'b0;
    ctrl.sel     = pSel;
    ctrl.addrSel = pSel;
    unique case (phase)
      PH_FETCH: ctrl.bump = 1'b1;
      PH_EXEC: begin
        ctrl.sel = nNib;
        if (iNib == OPC_INC) ctrl.bump = 1'b1;
        if (iNib == OPC_DEC) ctrl.down = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_FETCH;
      pSel  <= '0;
      xSel  <= '0;
      iNib  <= '0;
      nNib  <= '0;
      tSave <= '0;
      intEn <= 1'b1;
    end else begin
      unique case (phase)
        PH_FETCH: begin
          iNib  <= memRdata[OP_W-1:NIB_W];
          nNib  <= memRdata[NIB_W-1:0];
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          if (iNib == OPC_SEP) pSel <= nNib;
          if (iNib == OPC_SEX) xSel <= nNib;
          phase <= (irq && intEn) ? PH_INTR : PH_FETCH;
        end
        default: begin
          tSave <= {xSel, pSel};
          xSel  <= INT_X;
          pSel  <= INT_P;
          intEn <= 1'b0;
          phase <= PH_FETCH;
        end
      endcase
    end
  end
endmodule

// File: rtl/ptrSeq.sv
module ptrSeq
  import ptrSeqPkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [REG_W-1:0] memAddr,
  output logic             memRd,
  input  logic [7:0]       memRdata,
  input  logic             irq,
  output logic [3:0]       dbgP,
  output logic [3:0]       dbgX,
  output logic [3:0]       dbgI,
  output logic [3:0]       dbgN,
  output logic [7:0]       dbgT
);
  dpCtrl_t ctrl;

  ptrSeqCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .memRdata (memRdata),
    .irq      (irq),
    .memRd    (memRd),
    .ctrl     (ctrl),
    .pSel     (dbgP),
    .xSel     (dbgX),
    .iNib     (dbgI),
    .nNib     (dbgN),
    .tSave    (dbgT)
  );

  ptrSeqDatapath #(.REG_W(REG_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .memAddr (memAddr)
  );
endmodule

// File: rtl/ptrSeqChecker.sv
module ptrSeqChecker (
  input logic       clk,
  input logic       rstN,
  input logic       memRd,
  input logic [3:0] dbgP,
  input logic [3:0] dbgX,
  input logic [3:0] dbgI,
  input logic [3:0] dbgN,
  input logic [7:0] dbgT
);
  // R2: a fetch is always followed by a non-fetch cycle
  a_r2_fetch_then_exec: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> !memRd);

  // R4: execute of 0xDn moves N into P
  a_r4_sep_loads_p: assert property (@(posedge clk) disable iff (!rstN)
    ($past(memRd) && !memRd && dbgI == 4'hD) |=> (dbgP == $past(dbgN)));

  // R5: execute of 0xEn moves N into X
  a_r5_sex_loads_x: assert property (@(posedge clk) disable iff (!rstN)
    ($past(memRd) && !memRd && dbgI == 4'hE) |=> (dbgX == $past(dbgN)));

  // R7: execute of a no-operation opcode leaves selectors alone
  a_r7_nop_keeps_sel: assert property (@(posedge clk) disable iff (!rstN)
    ($past(memRd) && !memRd && dbgI == 4'hC) |=> ($stable(dbgP) && $stable(dbgX)));

  // R8: entry cycle (second non-fetch cycle) forces selectors and saves them
  a_r8_entry_values: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(memRd) && !memRd) |=>
      (dbgP == 4'd1 && dbgX == 4'd2 && dbgT == $past({dbgX, dbgP})));

  // R8: a fetch always follows the entry cycle
  a_r8_fetch_after_entry: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(memRd) && !memRd) |=> memRd);
endmodule

bind ptrSeq ptrSeqChecker u_chk (.*);

// File: tb/ptrSeq_tb.sv
module ptrSeq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memAddr;
  logic        memRd;
  logic [7:0]  memRdata;
  logic        irq = 1'b0;
  logic [3:0]  dbgP, dbgX, dbgI, dbgN;
  logic [7:0]  dbgT;

  logic [7:0]  mem [256];
  assign memRdata = mem[memAddr[7:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptrSeq u_dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd),
    .memRdata(memRdata), .irq(irq), .dbgP(dbgP), .dbgX(dbgX),
    .dbgI(dbgI), .dbgN(dbgN), .dbgT(dbgT)
  );

  int checks = 0;
  int fails  = 0;

  // reference state computed from the requirements
  logic [15:0] mR [16];
  logic [3:0]  mP, mX, mI, mN;
  logic [7:0]  mT;
  logic        mIe;
  int          mPh;
  string       lastTag;
  int          entries;
  int          lowRun;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 16; k++) mR[k] = '0;
    mP = 0; mX = 0; mI = 0; mN = 0; mT = 0; mIe = 1'b1; mPh = 0;
    lastTag = "R1"; entries = 0; lowRun = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; irq = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(dbgP == 0 && dbgX == 0, "R1", "selectors in reset", {dbgP, dbgX}, 0);
    rstN = 1'b1;
    modelReset();
    #1;
    chk(memRd == 1'b1, "R1", "first fetch strobe", memRd, 1);
    chk(memAddr == 16'h0000, "R1", "first fetch address", memAddr, 0);
    chk(dbgI == 0 && dbgN == 0 && dbgT == 0, "R1", "nibbles and T",
        {dbgI, dbgN, dbgT}, 0);
  endtask

  // one cycle: irq drive, compare, advance model
  task automatic stepCycle(input logic irqVal, input bit first);
    logic [7:0] b;
    if (!first) @(negedge clk);
    irq = irqVal;
    #1;
    chk(memRd == (mPh == 0), "R2", "memRd phase", memRd, (mPh == 0));
    if (mPh == 0)
      chk(memAddr == mR[mP], lastTag, "fetch address", memAddr, mR[mP]);
    chk(dbgI == mI && dbgN == mN, "R2", "I/N nibbles", {dbgI, dbgN}, {mI, mN});
    chk(dbgP == mP, "R4", "P selector", dbgP, mP);
    chk(dbgX == mX, "R5", "X selector", dbgX, mX);
    chk(dbgT == mT, "R8", "saved T", dbgT, mT);
    if (!memRd) lowRun++; else lowRun = 0;
    chk(lowRun <= 2, "R9", "non-fetch run length", lowRun, 2);
    case (mPh)
      0: begin
        b = mem[mR[mP][7:0]];
        mI = b[7:4]; mN = b[3:0];
        mR[mP] = mR[mP] + 16'd1;
        lastTag = "R3";
        mPh = 1;
      end
      1: begin
        case (mI)
          4'h1: begin mR[mN] = mR[mN] + 16'd1; lastTag = "R6"; end
          4'h2: begin mR[mN] = mR[mN] - 16'd1; lastTag = "R6"; end
          4'hD: begin mP = mN; lastTag = "R4"; end
          4'hE: begin mX = mN; lastTag = "R5"; end
          default: lastTag = "R7";
        endcase
        if (irqVal && mIe) mPh = 2;
        else begin
          if (irqVal) lastTag = "R9";
          mPh = 0;
        end
      end
      default: begin
        mT = {mX, mP}; mX = 4'd2; mP = 4'd1; mIe = 1'b0;
        mPh = 0; lastTag = "R8"; entries++;
      end
    endcase
  endtask

  initial begin
    int k;
    int n;
    for (int i = 0; i < 256; i++) begin
      k = (i * 5 + 3) % 7;
      n = (i * 11 + i / 16) % 16;
      case (k)
        0, 6: mem[i] = 8'h10 | 8'(n);
        1:    mem[i] = 8'h20 | 8'(n);
        2:    mem[i] = 8'hD0 | 8'(n);
        3:    mem[i] = 8'hE0 | 8'(n);
        4:    mem[i] = 8'hC4;
        default: mem[i] = 8'h30 | 8'(n);
      endcase
    end
    // R6 wrap below zero, then R3 wrap above 0xFFFF through register 5
    mem[0]   = 8'h25;
    mem[1]   = 8'hD5;
    mem[255] = 8'h15;

    // run 1: long sweep, request held from cycle 400 on
    doReset();
    for (int c = 0; c < 1600; c++) stepCycle((c >= 400), (c == 0));
    chk(entries == 1, "R9", "entries with held request", entries, 1);

    // run 2: request from the start, entry right after first instruction
    doReset();
    for (int c = 0; c < 200; c++) stepCycle(1'b1, (c == 0));
    chk(entries == 1, "R8", "entry count after early request", entries, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule